// File: doc/BRIEF.md
# Byte-Lane Steering and Parity Unit for a Width-Configurable Bus

This block sits between a 32-bit processor core and an external data bus. The width of that bus can be 32, 16 or 8 bits, and it is chosen afresh for every transaction. The external address is word-aligned: only address bits 31..2 leave the block. The block therefore uses four byte-enable outputs to pick the bytes of the addressed word. On a narrow bus some of those enable outputs carry the low address bits instead. Write data is moved onto the lanes the bus actually uses. Read data is shifted back so that it arrives right-justified at the core.

A transaction can be a single beat or a burst of up to sixteen beats. In a burst the low four address bits advance by the access size and wrap inside the aligned 16-byte block. Each write beat gets one parity bit per active lane, with even or odd polarity. Each read beat is checked against the incoming parity bits, and this check can be turned off. A sticky error flag reports the result of the most recent read beat. It holds that value until the next read beat completes.

Top module: `bus_lane_unit`

## Requirements
- R1: While reset is asserted and after it is released, `bus_active`, `bus_be`, `bus_dout`, `bus_dpout`, `rd_valid` and `parity_err` are all 0.
- R2: Width code 2 selects a 32-bit bus. Enable bit i is 1 exactly when data byte [8i+7:8i] is addressed. A byte access (size 0) enables one lane at offset `req_addr[1:0]`. A halfword access (size 1) enables lanes 1:0 or 3:2, chosen by `req_addr[1]`. A word access (size 2) enables all four lanes.
- R3: Width code 1 selects a 16-bit bus. Enable 3 marks data 15:8 in use and enable 0 marks data 7:0 in use. Enable 1 carries address bit 1. Enable 2 is 0.
- R4: Width code 0 selects an 8-bit bus. Enable 1 carries address bit 1 and enable 0 carries address bit 0. Enables 3 and 2 are 0, and only lane 0 carries data or parity.
- R5: On a write, the right-justified `wr_data` is moved onto the used lanes. The shift is (`req_addr[1:0]` bytes) on a 32-bit bus, (`req_addr[0]` bytes) on a 16-bit bus, and none on an 8-bit bus. Unused lanes are 0.
- R6: On a write, `bus_dpout[i]` is the XOR of data byte i. That value is inverted when `cfg_odd` is 1. The bit is forced to 0 for any lane the access does not use.
- R7: On a read, `rd_data` is the addressed data shifted down to bit 0. Bits above the access size are 0.
- R8: A read beat has a parity error only when `cfg_chk_en` is 1 and the received parity bit of a used lane differs from the parity rule in R6. Unused lanes never cause an error.
- R9: `rd_valid` pulses in the cycle after a read beat is accepted through `bus_ready`. In that same cycle `parity_err` takes the result of that beat, and it then holds until the next read beat.
- R10: `bus_addr[29:2]` stays fixed for the whole transaction. The low four address bits advance by the effective access size after each beat and wrap within the 16-byte block. The transaction ends after `req_beats`+1 beats.
- R11: `bus_wr` is 1 for writes and 0 for reads. `bus_dc` is 1 for data accesses and 0 for instruction fetches. Both hold for the whole transaction.
- R12: A `req_valid` raised while a transaction is active is ignored. It is not queued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_odd | input | 1 | 1 selects odd parity, 0 even |
| cfg_chk_en | input | 1 | Enables read parity checking |
| req_valid | input | 1 | Starts a transaction when idle |
| req_write | input | 1 | 1 write, 0 read |
| req_data | input | 1 | 1 data access, 0 instruction fetch |
| req_width | input | 2 | Bus width: 0 = 8, 1 = 16, 2 or 3 = 32 bits |
| req_size | input | 2 | Access size: 0 byte, 1 halfword, 2 or 3 word |
| req_beats | input | 4 | Number of beats minus one |
| req_addr | input | 32 | Byte start address, aligned to the size |
| wr_data | input | 32 | Right-justified write data for the current beat |
| beat_done | output | 1 | Current beat accepted by the bus this cycle |
| rd_valid | output | 1 | Read data valid pulse |
| rd_data | output | 32 | Right-justified read data |
| parity_err | output | 1 | Parity result of the most recent read beat |
| bus_active | output | 1 | A transaction is in progress |
| bus_addr | output | 30 | Word address, bits 31..2 |
| bus_be | output | 4 | Byte enables and reused address bits |
| bus_wr | output | 1 | Write/read indicator |
| bus_dc | output | 1 | Data/code indicator |
| bus_dout | output | 32 | Write data lanes |
| bus_dpout | output | 4 | Write parity, one bit per lane |
| bus_din | input | 32 | Read data lanes |
| bus_dpin | input | 4 | Read parity, one bit per lane |
| bus_ready | input | 1 | Bus completes the current beat |

## Verification
Two functions can act in the same clock edge. A read beat that completes sets the sticky error flag, and the same edge also advances the burst address. On a wrapping burst the next beat is then presented at the new address in the cycle where the error is reported. The bench runs a four-beat read burst that crosses the 16-byte wrap and has corrupt parity on its second beat. It checks that the flag rises together with `rd_valid`, that it holds through an idle cycle while the third beat's wrapped address is already on the bus, and that it clears only when that third beat completes.

// File: rtl/bus_lane_pkg.sv
package bus_lane_pkg;
    localparam int BYTE_W = 8;
    localparam int LANE_N = 4;
    localparam int DATA_W = BYTE_W * LANE_N;
    localparam int ADDR_W = 32;
    localparam int BEAT_W = 4;
    localparam int BLK_W  = 4;
    localparam int OFF_W  = $clog2(LANE_N);

    typedef enum logic [1:0] {BW8 = 2'd0, BW16 = 2'd1, BW32 = 2'd2, BW32X = 2'd3} width_e;
    typedef enum logic [1:0] {SZ_B = 2'd0, SZ_H = 2'd1, SZ_W = 2'd2, SZ_WX = 2'd3} size_e;

    typedef struct packed {
        logic              busy;
        logic              wr;
        logic              dc;
        width_e            width;
        size_e             size;
        logic [ADDR_W-1:0] addr;
        logic [BEAT_W-1:0] left;
        logic              rd_valid;
        logic [DATA_W-1:0] rd_data;
        logic              perr;
    } ctl_state_t;

    // Access size clipped to what the bus can carry in one beat.
    function automatic size_e eff_size(width_e w, size_e s);
        size_e r;
        case (w)
            BW8:     r = SZ_B;
            BW16:    r = (s == SZ_B) ? SZ_B : SZ_H;
            default: r = (s == SZ_B) ? SZ_B : ((s == SZ_H) ? SZ_H : SZ_W);
        endcase
        return r;
    endfunction
endpackage

// File: rtl/bus_lane_map.sv
module bus_lane_map
    import bus_lane_pkg::*;
(
    input  width_e            width,
    input  size_e             size,
    input  logic [OFF_W-1:0]  low,
    output logic [LANE_N-1:0] lanes,
    output logic [LANE_N-1:0] be
);
    always_comb begin
        lanes = '0;
        be    = '0;
        case (width)
            BW8: begin
                lanes = 4'b0001;
                be    = {2'b00, low[1], low[0]};
            end
            BW16: begin
                if (size == SZ_B) lanes = low[0] ? 4'b0010 : 4'b0001;
                else              lanes = 4'b0011;
                be = {lanes[1], 1'b0, low[1], lanes[0]};
            end
            default: begin
                case (size)
                    SZ_B:    lanes = 4'b0001 << low;
                    SZ_H:    lanes = low[1] ? 4'b1100 : 4'b0011;
                    default: lanes = 4'b1111;
                endcase
                be = lanes;
            end
        endcase
    end
endmodule

// File: rtl/bus_lane_steer.sv
module bus_lane_steer
    import bus_lane_pkg::*;
(
    input  width_e            width,
    input  size_e             size,
    input  logic [OFF_W-1:0]  low,
    input  logic [LANE_N-1:0] lanes,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] lane_bits;
    logic [DATA_W-1:0] size_bits;
    logic [OFF_W-1:0]  sh;

    for (genvar i = 0; i < LANE_N; i++) begin : g_lane
        assign lane_bits[i*BYTE_W +: BYTE_W] = {BYTE_W{lanes[i]}};
    end

    always_comb begin
        case (width)
            BW8:     sh = '0;
            BW16:    sh = {1'b0, low[0]};
            default: sh = low;
        endcase
        case (size)
            SZ_B:    size_bits = DATA_W'({BYTE_W{1'b1}});
            SZ_H:    size_bits = DATA_W'({2*BYTE_W{1'b1}});
            default: size_bits = '1;
        endcase
        dout  = (wdata << {sh, 3'b000}) & lane_bits;
        rdata = (din >> {sh, 3'b000}) & size_bits;
    end
endmodule

// File: rtl/bus_lane_parity.sv
module bus_lane_parity
    import bus_lane_pkg::*;
(
    input  logic [DATA_W-1:0] data,
    input  logic [LANE_N-1:0] lanes,
    input  logic              odd,
    output logic [LANE_N-1:0] bits
);
    for (genvar i = 0; i < LANE_N; i++) begin : g_par
        assign bits[i] = lanes[i] & ((^data[i*BYTE_W +: BYTE_W]) ^ odd);
    end
endmodule

// File: rtl/bus_lane_unit.sv
module bus_lane_unit
    import bus_lane_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cfg_odd,
    input  logic        cfg_chk_en,
    input  logic        req_valid,
    input  logic        req_write,
    input  logic        req_data,
    input  logic [1:0]  req_width,
    input  logic [1:0]  req_size,
    input  logic [3:0]  req_beats,
    input  logic [31:0] req_addr,
    input  logic [31:0] wr_data,
    output logic        beat_done,
    output logic        rd_valid,
    output logic [31:0] rd_data,
    output logic        parity_err,
    output logic        bus_active,
    output logic [29:0] bus_addr,
    output logic [3:0]  bus_be,
    output logic        bus_wr,
    output logic        bus_dc,
    output logic [31:0] bus_dout,
    output logic [3:0]  bus_dpout,
    input  logic [31:0] bus_din,
    input  logic [3:0]  bus_dpin,
    input  logic        bus_ready
);
    ctl_state_t state_d, state_q;

    size_e             size_eff;
    width_e            cur_width;
    logic [LANE_N-1:0] lanes, be_raw, tx_bits, rx_bits;
    logic [DATA_W-1:0] tx_data, rx_data;
    logic [BLK_W-1:0]  step;
    logic              chk_err;

    assign size_eff  = eff_size(state_q.width, state_q.size);
    assign cur_width = state_q.width;

    bus_lane_map u_map (
        .width (state_q.width),
        .size  (size_eff),
        .low   (state_q.addr[OFF_W-1:0]),
        .lanes (lanes),
        .be    (be_raw)
    );

    bus_lane_steer u_steer (
        .width (state_q.width),
        .size  (size_eff),
        .low   (state_q.addr[OFF_W-1:0]),
        .lanes (lanes),
        .wdata (wr_data),
        .din   (bus_din),
        .dout  (tx_data),
        .rdata (rx_data)
    );

    bus_lane_parity u_par_tx (
        .data  (tx_data),
        .lanes (lanes),
        .odd   (cfg_odd),
        .bits  (tx_bits)
    );

    bus_lane_parity u_par_rx (
        .data  (bus_din),
        .lanes (lanes),
        .odd   (cfg_odd),
        .bits  (rx_bits)
    );

    assign chk_err = cfg_chk_en & (|(rx_bits ^ (bus_dpin & lanes)));
    assign step    = BLK_W'(1) << size_eff;

    always_comb begin
        state_d          = state_q;
        state_d.rd_valid = 1'b0;
        if (!state_q.busy) begin
            if (req_valid) begin
                state_d.busy  = 1'b1;
                state_d.wr    = req_write;
                state_d.dc    = req_data;
                state_d.width = width_e'(req_width);
                state_d.size  = size_e'(req_size);
                state_d.addr  = req_addr;
                state_d.left  = req_beats;
            end
        end else if (bus_ready) begin
            if (!state_q.wr) begin
                state_d.rd_valid = 1'b1;
                state_d.rd_data  = rx_data;
                state_d.perr     = chk_err;
            end
            state_d.addr = {state_q.addr[ADDR_W-1:BLK_W], state_q.addr[BLK_W-1:0] + step};
            if (state_q.left == '0) state_d.busy = 1'b0;
            else                    state_d.left = state_q.left - BEAT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign beat_done  = state_q.busy & bus_ready;
    assign rd_valid   = state_q.rd_valid;
    assign rd_data    = state_q.rd_data;
    assign parity_err = state_q.perr;
    assign bus_active = state_q.busy;
    assign bus_addr   = state_q.addr[ADDR_W-1:2];
    assign bus_be     = state_q.busy ? be_raw : '0;
    assign bus_wr     = state_q.busy & state_q.wr;
    assign bus_dc     = state_q.busy & state_q.dc;
    assign bus_dout   = (state_q.busy & state_q.wr) ? tx_data : '0;
    assign bus_dpout  = (state_q.busy & state_q.wr) ? tx_bits : '0;
endmodule

// File: rtl/bus_lane_chk.sv
module bus_lane_chk
    import bus_lane_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input width_e      cur_width,
    input logic        bus_active,
    input logic        bus_ready,
    input logic        bus_wr,
    input logic        bus_dc,
    input logic [29:0] bus_addr,
    input logic [3:0]  bus_be,
    input logic [31:0] bus_dout,
    input logic [3:0]  bus_dpout,
    input logic        rd_valid,
    input logic        parity_err
);
    // R4
    narrow_lanes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_active && cur_width == BW8 |-> bus_be[3:2] == 2'b00 && bus_dpout[3:1] == 3'b000);

    // R3
    half_be2_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_active && cur_width == BW16 |-> bus_be[2] == 1'b0);

    // R9
    rdv_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $past(bus_active && bus_ready && !bus_wr));

    // R9
    perr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_valid |-> $stable(parity_err));

    // R10
    block_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_active && $past(bus_active) |-> $stable(bus_addr[29:2]));

    // R11
    dir_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_active && $past(bus_active) |-> $stable(bus_wr) && $stable(bus_dc));

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_active |-> bus_be == 4'b0000 && bus_dout == 32'h0 && bus_dpout == 4'b0000);
endmodule

bind bus_lane_unit bus_lane_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cur_width  (cur_width),
    .bus_active (bus_active),
    .bus_ready  (bus_ready),
    .bus_wr     (bus_wr),
    .bus_dc     (bus_dc),
    .bus_addr   (bus_addr),
    .bus_be     (bus_be),
    .bus_dout   (bus_dout),
    .bus_dpout  (bus_dpout),
    .rd_valid   (rd_valid),
    .parity_err (parity_err)
);

// File: tb/bus_lane_unit_test.sv
`timescale 1ns/1ps
module bus_lane_unit_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_odd = 1'b0, cfg_chk_en = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0, req_data = 1'b0;
    logic [1:0]  req_width = '0, req_size = '0;
    logic [3:0]  req_beats = '0;
    logic [31:0] req_addr = '0, wr_data = '0;
    logic        beat_done, rd_valid, parity_err, bus_active, bus_wr, bus_dc;
    logic [31:0] rd_data, bus_dout;
    logic [29:0] bus_addr;
    logic [3:0]  bus_be, bus_dpout;
    logic [31:0] bus_din = '0;
    logic [3:0]  bus_dpin = '0;
    logic        bus_ready = 1'b0;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    bus_lane_unit uut (.*);

    typedef struct packed {
        logic        wr;
        logic        dc;
        logic [1:0]  width;
        logic [1:0]  size;
        logic [1:0]  low;
        logic        odd;
        logic        chk;
        logic [31:0] data;
        logic [3:0]  dp;
        logic [3:0]  exp_be;
        logic [31:0] exp_data;
        logic [3:0]  exp_dp;
        logic        exp_err;
    } vec_t;

    localparam int NV = 15;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 1'b1, 2'd2, 2'd2, 2'd0, 1'b0, 1'b0, 32'h01020304, 4'h0, 4'b1111, 32'h01020304, 4'b1101, 1'b0},
        '{1'b1, 1'b0, 2'd2, 2'd0, 2'd2, 1'b1, 1'b0, 32'h000000A5, 4'h0, 4'b0100, 32'h00A50000, 4'b0100, 1'b0},
        '{1'b1, 1'b1, 2'd2, 2'd1, 2'd2, 1'b0, 1'b0, 32'h00007F01, 4'h0, 4'b1100, 32'h7F010000, 4'b1100, 1'b0},
        '{1'b1, 1'b1, 2'd1, 2'd1, 2'd2, 1'b0, 1'b0, 32'h00008001, 4'h0, 4'b1011, 32'h00008001, 4'b0011, 1'b0},
        '{1'b1, 1'b0, 2'd1, 2'd0, 2'd1, 1'b1, 1'b0, 32'h000000FF, 4'h0, 4'b1000, 32'h0000FF00, 4'b0010, 1'b0},
        '{1'b1, 1'b1, 2'd0, 2'd0, 2'd3, 1'b0, 1'b0, 32'h00000007, 4'h0, 4'b0011, 32'h00000007, 4'b0001, 1'b0},
        '{1'b1, 1'b1, 2'd0, 2'd0, 2'd2, 1'b1, 1'b0, 32'h00000012, 4'h0, 4'b0010, 32'h00000012, 4'b0001, 1'b0},
        '{1'b0, 1'b1, 2'd2, 2'd2, 2'd0, 1'b0, 1'b1, 32'h01020304, 4'b1101, 4'b1111, 32'h01020304, 4'h0, 1'b0},
        '{1'b0, 1'b1, 2'd2, 2'd2, 2'd0, 1'b0, 1'b1, 32'h01020304, 4'b1100, 4'b1111, 32'h01020304, 4'h0, 1'b1},
        '{1'b0, 1'b0, 2'd2, 2'd0, 2'd1, 1'b0, 1'b1, 32'h1122AB44, 4'b0010, 4'b0010, 32'h000000AB, 4'h0, 1'b0},
        '{1'b0, 1'b1, 2'd2, 2'd1, 2'd2, 1'b1, 1'b1, 32'h3C000000, 4'b0100, 4'b1100, 32'h00003C00, 4'h0, 1'b1},
        '{1'b0, 1'b1, 2'd1, 2'd1, 2'd0, 1'b0, 1'b1, 32'hDEAD0102, 4'b0011, 4'b1001, 32'h00000102, 4'h0, 1'b0},
        '{1'b0, 1'b0, 2'd1, 2'd0, 2'd3, 1'b0, 1'b1, 32'h00008000, 4'b0000, 4'b1010, 32'h00000080, 4'h0, 1'b1},
        '{1'b0, 1'b1, 2'd0, 2'd0, 2'd1, 1'b0, 1'b0, 32'hFFFFFF03, 4'b0001, 4'b0001, 32'h00000003, 4'h0, 1'b0},
        '{1'b0, 1'b1, 2'd0, 2'd0, 2'd0, 1'b1, 1'b1, 32'h00000003, 4'b0000, 4'b0000, 32'h00000003, 4'h0, 1'b1}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic start(input logic wr, input logic dc, input logic [1:0] width,
                         input logic [1:0] size, input logic [31:0] addr, input logic [3:0] beats);
        @(negedge clk);
        req_write = wr; req_data = dc; req_width = width; req_size = size;
        req_addr = addr; req_beats = beats; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic beat(input logic [31:0] din, input logic [3:0] dp);
        bus_din = din; bus_dpin = dp; bus_ready = 1'b1;
        @(negedge clk);
        bus_ready = 1'b0;
    endtask

    initial begin
        #(8 * 200000);
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        check("R1 active", 32'(bus_active), 32'd0);
        check("R1 be", 32'(bus_be), 32'd0);
        check("R1 perr", 32'(parity_err), 32'd0);
        check("R1 rdv", 32'(rd_valid), 32'd0);
        check("R1 dout", bus_dout, 32'd0);
        rst_n = 1'b1;

        // Single-beat vectors: R2..R8, R11
        for (int i = 0; i < NV; i++) begin
            automatic vec_t v = VECS[i];
            automatic logic [31:0] a = 32'h12345670 | 32'(v.low);
            automatic string ber = (v.width == 2'd0) ? "R4 be" : ((v.width == 2'd1) ? "R3 be" : "R2 be");
            cfg_odd = v.odd; cfg_chk_en = v.chk;
            wr_data = v.wr ? v.data : 32'h0;
            start(v.wr, v.dc, v.width, v.size, a, 4'd0);
            check(ber, 32'(bus_be), 32'(v.exp_be));
            check("R10 addr", 32'(bus_addr), 32'(a[31:2]));
            check("R11 wr", 32'(bus_wr), 32'(v.wr));
            check("R11 dc", 32'(bus_dc), 32'(v.dc));
            if (v.wr) begin
                check("R5 dout", bus_dout, v.exp_data);
                check("R6 dp", 32'(bus_dpout), 32'(v.exp_dp));
            end
            beat(v.wr ? 32'h0 : v.data, v.wr ? 4'h0 : v.dp);
            if (!v.wr) begin
                check("R9 rdv", 32'(rd_valid), 32'd1);
                check("R7 rdata", rd_data, v.exp_data);
                check("R8 perr", 32'(parity_err), 32'(v.exp_err));
            end
            check("R10 end", 32'(bus_active), 32'd0);
        end

        // R10: 8-bit write burst wrapping inside the 16-byte block
        cfg_odd = 1'b0; cfg_chk_en = 1'b1;
        start(1'b1, 1'b1, 2'd0, 2'd0, 32'h0000ABCE, 4'd3);
        for (int k = 0; k < 4; k++) begin
            automatic logic [3:0] lo = 4'hE + 4'(k);
            automatic logic [31:0] ea = 32'h0000ABC0 | 32'(lo);
            wr_data = 32'h40 + 32'(k);
            #1;
            check("R10 addr", 32'(bus_addr), 32'(ea[31:2]));
            check("R4 be", 32'(bus_be), {30'd0, lo[1:0]});
            check("R5 dout", bus_dout, 32'h40 + 32'(k));
            beat(32'h0, 4'h0);
        end
        check("R10 end", 32'(bus_active), 32'd0);

        // R9/R10: 32-bit read burst, wrap, error on beat 1 held over idle cycle
        start(1'b0, 1'b1, 2'd2, 2'd2, 32'h00005558, 4'd3);
        check("R10 addr0", 32'(bus_addr), 32'(32'h00005558 >> 2));
        beat(32'h0F0F0F0F, 4'b0000);
        check("R8 perr0", 32'(parity_err), 32'd0);
        check("R10 addr1", 32'(bus_addr), 32'(32'h0000555C >> 2));
        beat(32'h0F0F0F0F, 4'b0001);
        check("R9 rdv1", 32'(rd_valid), 32'd1);
        check("R8 perr1", 32'(parity_err), 32'd1);
        check("R10 wrap", 32'(bus_addr), 32'(32'h00005550 >> 2));
        @(negedge clk);
        check("R9 hold", 32'(parity_err), 32'd1);
        check("R9 rdv idle", 32'(rd_valid), 32'd0);
        beat(32'h0F0F0F0F, 4'b0000);
        check("R9 clear", 32'(parity_err), 32'd0);
        check("R10 addr3", 32'(bus_addr), 32'(32'h00005554 >> 2));
        beat(32'h12345678, 4'b0000);
        check("R7 rdata3", rd_data, 32'h12345678);
        check("R10 end", 32'(bus_active), 32'd0);

        // R12: request while busy is dropped
        start(1'b0, 1'b0, 2'd2, 2'd2, 32'h00001000, 4'd1);
        req_write = 1'b1; req_addr = 32'hFFFFFFF0; req_beats = 4'd0; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        check("R12 addr", 32'(bus_addr), 32'(32'h00001000 >> 2));
        check("R12 wr", 32'(bus_wr), 32'd0);
        beat(32'h0, 4'h0);
        check("R12 addr1", 32'(bus_addr), 32'(32'h00001004 >> 2));
        beat(32'h0, 4'h0);
        @(negedge clk);
        check("R12 idle", 32'(bus_active), 32'd0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule